// File: doc/BRIEF.md
# Half-Step Inverting Ring Shift Register

This block is a cycle-accurate digital model of a closed serial loop built from inverting delay stages. Its clock runs at twice the rate of an external rotating drive, so one clock edge (a "tick") is half a drive period. Each stage holds one bit, inverts it and passes it on one tick later. After the last stage a return path adds two more ticks before the bit re-enters the first stage. A logic 1 stands for a state aligned with the direction of data flow and a logic 0 for the opposite alignment.

Every stage exposes its bit on a parallel tap, so the loop also serves as a serial-in, parallel-out register. The last stage is the serial observation point. One stage, chosen by parameter, can be forced from a global write strobe while all other stages keep shifting. Dropping the run enable freezes the entire loop, and shifting resumes from the same state. With an odd stage count N the loop runs free with a period of N+2 drive periods. With an even count it holds whatever pattern was written into it.

Top module: `inv_ring_shifter`

## Requirements
- R1: While reset (active-low `rstN`) is asserted, and after it is released, stage i holds bit (i mod 2), so stage 0 holds 0 and stage 1 holds 1. Both return-path registers hold the reset value of the last stage.
- R2: On a tick with `runEn` high, each stage i ≥ 1 that is not being written takes the inverse of the value stage i-1 held before that tick.
- R3: On a tick with `runEn` high, stage 0 (when not being written) takes the inverse of the value the last stage held three enabled ticks earlier. This is two ticks of return path plus its own tick.
- R4: With an odd stage count N and no writes, `obsOut` settles into a square wave of 2·(N+2) ticks: each level lasts N+2 ticks. For N=1 the first high level covers ticks 1 to 3 after reset.
- R5: With an even stage count and no writes, every tap keeps its reset value indefinitely while running.
- R6: On a tick with `runEn` and `wrStrobe` high, stage WRITE_STAGE takes `wrData`, while all other stages shift as in R2/R3 on that same tick.
- R7: A sequence written on consecutive ticks into an even loop reappears at the write stage every N+2 ticks without being rewritten (for example 1,1,0,1,0 in an 8-stage loop).
- R8: On a tick with `runEn` low, all stages and return registers hold, and `wrStrobe` is ignored. Shifting continues from the held state once `runEn` returns.
- R9: `obsOut` equals the tap of the last stage (index NUM_STAGES-1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, two ticks per drive period |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Drive present; low stalls the whole loop |
| wrStrobe | input | 1 | Force the write stage on this tick |
| wrData | input | 1 | Value forced into the write stage |
| taps | output | NUM_STAGES | Parallel tap, bit i is stage i |
| obsOut | output | 1 | Serial observation point (last stage) |

## Verification
A write strobe can coincide with a stall. In that case the stall must win and the write stage must keep its bit. The bench provokes this by holding `runEn` low with `wrStrobe` high and `wrData` set to the inverse of the write-stage tap for several ticks. It then confirms that every tap and `obsOut` are unchanged and that, after resuming, ten enabled ticks bring the 8-stage loop back to the same taps. A write can also coincide with normal shifting. Every write tick is therefore judged at the write stage and, on the same tick, at its neighbours, which must show the inverse of their predecessors' old bits.

// File: rtl/inv_ring_pkg.sv
package inv_ring_pkg;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic advance;   // drive present: every stage moves on this tick
    logic load;      // force the write stage this tick
    logic loadBit;   // value to force
  } ringStrobes_t;

  // Return path length in ticks (one full drive period)
  localparam int RETURN_TICKS = 2;

  // Reset value of stage idx: alternating, so an even loop is at rest
  function automatic logic stageResetBit(input int idx);
    return logic'(idx % 2);
  endfunction

endpackage

// File: rtl/inv_ring_ctrl.sv
module inv_ring_ctrl
  import inv_ring_pkg::*;
(
  input  logic         runEn,
  input  logic         wrStrobe,
  input  logic         wrData,
  output ringStrobes_t strobes
);

  // A stalled tick can neither shift nor write
  always_comb begin
    strobes.advance = runEn;
    strobes.load    = runEn & wrStrobe;
    strobes.loadBit = wrData;
  end

endmodule

// File: rtl/inv_ring_stage.sv
module inv_ring_stage #(
  parameter logic RESET_BIT = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic advance,
  input  logic load,
  input  logic loadBit,
  input  logic din,
  output logic q
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        q <= RESET_BIT;
    else if (load)    q <= loadBit;
    else if (advance) q <= ~din;
  end

endmodule

// File: rtl/inv_ring_return.sv
module inv_ring_return #(
  parameter int   DEPTH     = 2,
  parameter logic RESET_BIT = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic advance,
  input  logic din,
  output logic dout
);

  logic [DEPTH-1:0] pipe;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)        pipe <= RESET_BIT;
        else if (advance) pipe <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)        pipe <= {DEPTH{RESET_BIT}};
        else if (advance) pipe <= {pipe[DEPTH-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe[DEPTH-1];

endmodule

// File: rtl/inv_ring_datapath.sv
module inv_ring_datapath
  import inv_ring_pkg::*;
#(
  parameter int NUM_STAGES  = 8,
  parameter int WRITE_STAGE = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ringStrobes_t          strobes,
  output logic [NUM_STAGES-1:0] taps
);

  localparam logic LAST_RESET = stageResetBit(NUM_STAGES - 1);

  logic returnBit;
  logic [NUM_STAGES-1:0] stageIn;

  inv_ring_return #(
    .DEPTH    (RETURN_TICKS),
    .RESET_BIT(LAST_RESET)
  ) u_return (
    .clk    (clk),
    .rstN   (rstN),
    .advance(strobes.advance),
    .din    (taps[NUM_STAGES-1]),
    .dout   (returnBit)
  );

  generate
    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
      logic stageLoad;
      if (i == 0) begin : g_head
        assign stageIn[i] = returnBit;
      end else begin : g_body
        assign stageIn[i] = taps[i-1];
      end
      if (i == WRITE_STAGE) begin : g_wr
        assign stageLoad = strobes.load;
      end else begin : g_nowr
        assign stageLoad = 1'b0;
      end
      inv_ring_stage #(
        .RESET_BIT(stageResetBit(i))
      ) u_stage (
        .clk    (clk),
        .rstN   (rstN),
        .advance(strobes.advance),
        .load   (stageLoad),
        .loadBit(strobes.loadBit),
        .din    (stageIn[i]),
        .q      (taps[i])
      );
    end
  endgenerate

endmodule

// File: rtl/inv_ring_shifter.sv
module inv_ring_shifter
  import inv_ring_pkg::*;
#(
  parameter int NUM_STAGES  = 8,
  parameter int WRITE_STAGE = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  runEn,
  input  logic                  wrStrobe,
  input  logic                  wrData,
  output logic [NUM_STAGES-1:0] taps,
  output logic                  obsOut
);

  ringStrobes_t strobes;

  inv_ring_ctrl u_ctrl (
    .runEn   (runEn),
    .wrStrobe(wrStrobe),
    .wrData  (wrData),
    .strobes (strobes)
  );

  inv_ring_datapath #(
    .NUM_STAGES (NUM_STAGES),
    .WRITE_STAGE(WRITE_STAGE)
  ) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .taps   (taps)
  );

  assign obsOut = taps[NUM_STAGES-1];

endmodule

// File: rtl/inv_ring_chk.sv
module inv_ring_chk #(
  parameter int NUM_STAGES  = 8,
  parameter int WRITE_STAGE = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  runEn,
  input logic                  wrStrobe,
  input logic                  wrData,
  input logic [NUM_STAGES-1:0] taps
);

  // Consecutive enabled ticks since reset, saturating at 3
  logic [1:0] runStreak;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   runStreak <= '0;
    else if (!runEn)             runStreak <= '0;
    else if (runStreak != 2'd3)  runStreak <= runStreak + 2'd1;
  end

  generate
    for (genvar i = 1; i < NUM_STAGES; i++) begin : g_inv
      // R2
      stage_invert_chk: assert property (@(posedge clk) disable iff (!rstN)
        (runEn && !(wrStrobe && (i == WRITE_STAGE))) |=> (taps[i] == ~$past(taps[i-1])));
    end
  endgenerate

  // R3
  return_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && (runStreak >= 2'd2) && !(wrStrobe && (WRITE_STAGE == 0)))
      |=> (taps[0] == ~$past(taps[NUM_STAGES-1], 3)));

  // R6
  write_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && wrStrobe) |=> (taps[WRITE_STAGE] == $past(wrData)));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> $stable(taps));

endmodule

bind inv_ring_shifter inv_ring_chk #(
  .NUM_STAGES (NUM_STAGES),
  .WRITE_STAGE(WRITE_STAGE)
) u_inv_ring_chk (
  .clk     (clk),
  .rstN    (rstN),
  .runEn   (runEn),
  .wrStrobe(wrStrobe),
  .wrData  (wrData),
  .taps    (taps)
);

// File: tb/inv_ring_shifter_bench.sv
`timescale 1ns/1ps
module inv_ring_shifter_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 1'b0;
  logic wrStrobe = 1'b0;
  logic wrData = 1'b0;
  logic noWrite = 1'b0;

  logic [7:0]  taps8;
  logic        obs8;
  logic [0:0]  taps1;
  logic        obs1;
  logic [10:0] taps11;
  logic        obs11;

  int total = 0;
  int failed = 0;

  always #10 clk = ~clk;  // 50 MHz

  inv_ring_shifter #(.NUM_STAGES(8), .WRITE_STAGE(3)) u_inv_ring_shifter (
    .clk(clk), .rstN(rstN), .runEn(runEn), .wrStrobe(wrStrobe), .wrData(wrData),
    .taps(taps8), .obsOut(obs8));

  inv_ring_shifter #(.NUM_STAGES(1), .WRITE_STAGE(0)) u_odd1 (
    .clk(clk), .rstN(rstN), .runEn(runEn), .wrStrobe(noWrite), .wrData(wrData),
    .taps(taps1), .obsOut(obs1));

  inv_ring_shifter #(.NUM_STAGES(11), .WRITE_STAGE(5)) u_odd11 (
    .clk(clk), .rstN(rstN), .runEn(runEn), .wrStrobe(noWrite), .wrData(wrData),
    .taps(taps11), .obsOut(obs11));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One tick, then sample well after the edge
  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic doReset();
    rstN = 1'b0; runEn = 1'b0; wrStrobe = 1'b0; wrData = 1'b0;
    repeat (3) @(posedge clk);
    #5 rstN = 1'b1;
  endtask

  task automatic testReset();
    doReset();
    check(taps8 == 8'hAA, "R1 taps8", taps8, 8'hAA);
    check(taps11 == 11'h2AA, "R1 taps11", taps11, 11'h2AA);
    check(taps1 == 1'b0, "R1 taps1", taps1, 0);
    check(obs8 == 1'b1, "R9 obs8 after reset", obs8, 1);
  endtask

  task automatic testEvenHold();
    bit allSame = 1'b1;
    doReset();
    runEn = 1'b1;
    for (int k = 0; k < 40; k++) begin
      tick();
      if (taps8 != 8'hAA) allSame = 1'b0;
    end
    check(allSame, "R5 even loop at rest", taps8, 8'hAA);
  endtask

  task automatic testOdd(input int sel);
    logic hist [0:199];
    int h;
    int toggles;
    logic [10:0] prev;
    bit invOk;
    h = (sel == 1) ? 3 : 13;
    doReset();
    runEn = 1'b1;
    invOk = 1'b1;
    for (int k = 1; k <= 4 * h; k++) begin
      prev = taps11;
      tick();
      if (sel == 1) begin
        if (k == 1) check(obs1 == 1'b1, "R4 N=1 first tick high", obs1, 1);
        if (k == 3) check(obs1 == 1'b1, "R3 N=1 still high at tick 3", obs1, 1);
        if (k == 4) check(obs1 == 1'b0, "R3 N=1 low at tick 4", obs1, 0);
      end else begin
        for (int i = 1; i < 11; i++)
          if (taps11[i] != ~prev[i-1]) invOk = 1'b0;
      end
    end
    if (sel != 1) check(invOk, "R2 N=11 stage inversion", taps11, ~{prev[9:0], 1'b0});
    for (int k = 0; k < 4 * h; k++) begin
      tick();
      hist[k] = (sel == 1) ? obs1 : obs11;
    end
    toggles = 0;
    for (int t = 0; t < 2 * h; t++) begin
      check(hist[t + h] == ~hist[t], "R4 half-period inversion", hist[t + h], ~hist[t]);
      if (hist[t] != hist[t + 1]) toggles++;
    end
    check(toggles == 2, "R4 two edges per period", toggles, 2);
    check(obs11 == taps11[10] && obs1 == taps1[0], "R9 odd obs is last tap", obs11, taps11[10]);
  endtask

  task automatic testWrite();
    logic [4:0] bits = 5'b01011;  // bits[0..4] = 1,1,0,1,0
    logic [7:0] hist [0:59];
    logic obsHist [0:59];
    logic [7:0] prev;
    doReset();
    runEn = 1'b1;
    for (int k = 0; k < 60; k++) begin
      if (k < 5) begin
        wrStrobe = 1'b1;
        wrData = bits[k];
      end else begin
        wrStrobe = 1'b0;
      end
      prev = taps8;
      tick();
      hist[k] = taps8;
      obsHist[k] = obs8;
      if (k < 5) begin
        check(taps8[3] == bits[k], "R6 write stage takes data", taps8[3], bits[k]);
        check(taps8[4] == ~prev[3] && taps8[2] == ~prev[1],
              "R6 neighbours shift on write tick", taps8, prev);
      end
    end
    wrStrobe = 1'b0;
    for (int k = 5; k < 60; k++) begin
      if ((k % 10) < 5)
        check(hist[k][3] == bits[k % 10], "R7 pattern recirculates", hist[k][3], bits[k % 10]);
      if (k >= 9 && ((k - 4) % 10) < 5)
        check(obsHist[k] == bits[(k - 4) % 10], "R9 obs carries pattern",
              obsHist[k], bits[(k - 4) % 10]);
      if (k >= 3)
        check(hist[k][0] == ~hist[k-3][7], "R3 return path delay", hist[k][0], ~hist[k-3][7]);
    end
  endtask

  task automatic testStall();
    logic [7:0] snap;
    snap = taps8;
    runEn = 1'b0;
    wrStrobe = 1'b1;
    wrData = ~snap[3];
    for (int k = 0; k < 6; k++) begin
      tick();
      check(taps8 == snap, "R8 stall holds taps, write ignored", taps8, snap);
      check(obs8 == snap[7], "R8 stall holds obs", obs8, snap[7]);
    end
    wrStrobe = 1'b0;
    runEn = 1'b1;
    tick();
    check(taps8[4] == ~snap[3] && taps8[3] == ~snap[2], "R8 resume from held state",
          taps8, snap);
    repeat (9) tick();
    check(taps8 == snap, "R8 loop returns after 10 enabled ticks", taps8, snap);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    failed++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    testReset();
    testEvenHold();
    testOdd(1);
    testOdd(11);
    testWrite();
    testStall();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule